// File: doc/BRIEF.md
# Packed Word Insert Unit

This execution unit writes one 16-bit word into a chosen lane of a vector operand and returns the updated vector one clock later. The word always comes from the low half of a 32-bit scalar operand. The operation selects the lane from the low bits of an 8-bit immediate. The unit has three forms, chosen by a 2-bit mode input:

- **64-bit form:** works only on the low 64 bits of the vector and passes the remaining bits through unchanged.
- **Legacy 128-bit form:** updates the low 128 bits and leaves every bit above 127 as it was.
- **Three-operand form:** copies the vector input, replaces the chosen lane and clears every bit from 128 upward.

The three-operand form also checks a 2-bit vector-length field. If that field is nonzero, the unit raises an undefined-opcode fault instead of writing.

The surrounding pipeline must handle the rest of the instruction. It decodes the instruction and reads the destination or first-source register onto `vec_in`. It presents the scalar and the immediate, and pulses `in_valid`. On the next cycle it takes either a write request (`wr_en` with `res_out`) or a fault (`ud_fault`). The unit reads no status flags and writes none. It also ignores the operand-width bit.

Top module: `word_insert_unit`

## Requirements
- R1: While reset is asserted, and after it is released with no operation yet issued, `res_out` is all zeros and both `wr_en` and `ud_fault` are 0.
- R2: The inserted word is `scalar_in[15:0]`; bits [31:16] of the scalar have no effect on the result.
- R3: With `mode` = 0 (64-bit form), `imm[1:0]` selects lane 0 to 3 (bits 16*lane+15 down to 16*lane). Immediate bits [7:2] are ignored. The other lanes of the low 64 bits keep their input values, and bits VLEN-1 down to 64 equal `vec_in`.
- R4: With `mode` = 1 (legacy 128-bit form), `imm[2:0]` selects lane 0 to 7 and immediate bits [7:3] are ignored. The other lanes of the low 128 bits keep their input values, and bits VLEN-1 down to 128 equal `vec_in`.
- R5: With `mode` = 2 or 3 (three-operand form) and `vlen_field` = 0, `imm[2:0]` selects lane 0 to 7. The result is `vec_in` with that lane replaced and bits VLEN-1 down to 128 forced to 0.
- R6: In the three-operand form with `vlen_field` nonzero (1, 2 or 3), the unit sets `ud_fault` = 1 and `wr_en` = 0, and `res_out` keeps its previous value. In modes 0 and 1, `vlen_field` has no effect and never causes a fault.
- R7: `w_bit` has no effect: results and faults are identical for `w_bit` = 0 and 1.
- R8: An operation presented with `in_valid` = 1 at a clock edge appears on `res_out`, `wr_en` and `ud_fault` after that edge, for one cycle. In a cycle that follows an edge with `in_valid` = 0, `wr_en` and `ud_fault` are 0 and `res_out` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| mode | input | 2 | 0: 64-bit form, 1: legacy 128-bit form, 2/3: three-operand form |
| vec_in | input | VLEN | Destination or first-source vector |
| scalar_in | input | 32 | Scalar source; low word is inserted |
| imm | input | 8 | Immediate lane selector |
| vlen_field | input | 2 | Vector-length field; nonzero faults in the three-operand form |
| w_bit | input | 1 | Operand-width bit, ignored |
| res_out | output | VLEN | Registered result vector |
| wr_en | output | 1 | Result write request |
| ud_fault | output | 1 | Undefined-opcode fault |

## Verification
The bench visits every lane in each form, and it sets the immediate bits above the lane field each time. A design that decoded one bit too many would then land in the wrong lane or write past 64 bits in the narrow form.

It fills the upper vector bits with random data in every form. A unit that mixed up keep and clear would then show stale or zeroed high bits. It sends all three nonzero length codes in the three-operand form and a nonzero code in the other forms. A faulting operation that still wrote, or a legacy operation that trapped, would then miscompare.

Random scalars with busy upper halves catch a unit that takes the wrong half of the scalar. Runs with `w_bit` toggled catch any dependence on the width bit.

// File: rtl/word_insert_unit.sv
module word_insert_unit #(
  parameter int VLEN = 512
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [1:0]      mode,
  input  logic [VLEN-1:0] vec_in,
  input  logic [31:0]     scalar_in,
  input  logic [7:0]      imm,
  input  logic [1:0]      vlen_field,
  input  logic            w_bit,
  output logic [VLEN-1:0] res_out,
  output logic            wr_en,
  output logic            ud_fault
);
  localparam int WORD = 16;
  localparam int LIM  = 128;

  logic [WORD-1:0] word;
  logic            three_op;
  logic            fault;
  logic            commit;
  logic [VLEN-1:0] nxt;
  logic            unused_bits;

  assign word        = scalar_in[WORD-1:0];
  assign three_op    = mode[1];
  assign fault       = in_valid & three_op & (|vlen_field);
  assign commit      = in_valid & ~fault;
  assign unused_bits = ^{w_bit, scalar_in[31:WORD], imm[7:3]};

  always_comb begin
    nxt = vec_in;
    if (mode == 2'd0)
      nxt[int'(imm[1:0])*WORD +: WORD] = word;
    else
      nxt[int'(imm[2:0])*WORD +: WORD] = word;
    if (three_op)
      for (int b = LIM; b < VLEN; b++) nxt[b] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_out  <= '0;
      wr_en    <= 1'b0;
      ud_fault <= 1'b0;
    end else begin
      wr_en    <= commit;
      ud_fault <= fault;
      if (commit) res_out <= nxt;
    end
  end
endmodule

module word_insert_chk #(
  parameter int VLEN = 512
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [1:0]      mode,
  input logic [VLEN-1:0] vec_in,
  input logic [31:0]     scalar_in,
  input logic [7:0]      imm,
  input logic [1:0]      vlen_field,
  input logic [VLEN-1:0] res_out,
  input logic            wr_en,
  input logic            ud_fault
);
  logic [2:0]  lane_q;
  logic [15:0] word_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lane_q <= '0;
      word_q <= '0;
    end else begin
      lane_q <= (mode == 2'd0) ? {1'b0, imm[1:0]} : imm[2:0];
      word_q <= scalar_in[15:0];
    end
  end

  assert_lane_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> res_out[int'(lane_q)*16 +: 16] == word_q);

  assert_narrow_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && $past(mode) == 2'd0 |-> (res_out >> 64) == ($past(vec_in) >> 64));

  assert_legacy_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && $past(mode) == 2'd1 |-> (res_out >> 128) == ($past(vec_in) >> 128));

  assert_three_op_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && $past(mode[1]) |-> (res_out >> 128) == '0);

  assert_fault_blocks_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ud_fault |-> !wr_en && $stable(res_out));

  assert_fault_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ud_fault |-> $past(in_valid && mode[1] && vlen_field != 2'd0));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> !wr_en && !ud_fault && $stable(res_out));
endmodule

bind word_insert_unit word_insert_chk #(.VLEN(VLEN)) u_chk (.*);

// File: tb/sim_word_insert_unit.sv
module sim_word_insert_unit;
  localparam int VLEN = 512;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [1:0]      mode = '0;
  logic [VLEN-1:0] vec_in = '0;
  logic [31:0]     scalar_in = '0;
  logic [7:0]      imm = '0;
  logic [1:0]      vlen_field = '0;
  logic            w_bit = 1'b0;
  logic [VLEN-1:0] res_out;
  logic            wr_en;
  logic            ud_fault;

  typedef struct {
    logic [VLEN-1:0] res;
    logic            we;
    logic            ud;
    string           tag;
  } item_t;

  item_t           sb[$];
  logic [VLEN-1:0] held = '0;
  int              n_vec = 0;
  int              n_bad = 0;
  bit              finished = 1'b0;

  always #10 clk = ~clk;

  word_insert_unit #(.VLEN(VLEN)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .vec_in(vec_in), .scalar_in(scalar_in), .imm(imm),
    .vlen_field(vlen_field), .w_bit(w_bit),
    .res_out(res_out), .wr_en(wr_en), .ud_fault(ud_fault)
  );

  function automatic logic [VLEN-1:0] rnd_vec();
    logic [VLEN-1:0] v;
    for (int k = 0; k < VLEN / 32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic compare(string tag, logic [VLEN-1:0] er, logic ew, logic eu);
    n_vec++;
    if (res_out !== er || wr_en !== ew || ud_fault !== eu) begin
      n_bad++;
      $display("FAIL %s: got res=%h we=%b ud=%b exp res=%h we=%b ud=%b",
               tag, res_out, wr_en, ud_fault, er, ew, eu);
    end
  endtask

  task automatic apply(logic [1:0] m, logic [VLEN-1:0] v, logic [31:0] s,
                       logic [7:0] i, logic [1:0] vl, logic w, string tag);
    item_t it;
    int    lanes;
    int    sel;
    it.tag = tag;
    if (m[1] && vl != 2'd0) begin
      it.res = held; it.we = 1'b0; it.ud = 1'b1;
    end else begin
      lanes = (m == 2'd0) ? 4 : 8;
      sel   = (m == 2'd0) ? int'(i[1:0]) : int'(i[2:0]);
      it.res = v;
      for (int l = 0; l < lanes; l++)
        if (l == sel) it.res[l*16 +: 16] = s[15:0];
      if (m[1]) for (int b = 128; b < VLEN; b++) it.res[b] = 1'b0;
      it.we = 1'b1; it.ud = 1'b0;
      held = it.res;
    end
    sb.push_back(it);
    @(posedge clk); #2;
    in_valid = 1'b1; mode = m; vec_in = v; scalar_in = s;
    imm = i; vlen_field = vl; w_bit = w;
  endtask

  task automatic idle(int n);
    @(posedge clk); #2;
    in_valid = 1'b0;
    mode = 2'($urandom); vec_in = rnd_vec(); scalar_in = $urandom;
    imm = 8'($urandom); vlen_field = 2'($urandom);
    repeat (n - 1) @(posedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && (wr_en || ud_fault)) begin
      if (sb.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL R8: unexpected output we=%b ud=%b, expected none", wr_en, ud_fault);
      end else begin
        item_t it;
        it = sb.pop_front();
        compare(it.tag, it.res, it.we, it.ud);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [VLEN-1:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1 in reset", '0, 1'b0, 1'b0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    compare("R1 after reset", '0, 1'b0, 1'b0);

    for (int l = 0; l < 4; l++)
      apply(2'd0, rnd_vec(), $urandom, 8'hFC | 8'(l), 2'($urandom), 1'b0, "R3 narrow lane");
    for (int l = 0; l < 8; l++)
      apply(2'd1, rnd_vec(), $urandom, 8'hF8 | 8'(l), 2'd0, 1'b0, "R4 legacy lane");
    for (int l = 0; l < 8; l++)
      apply(2'd2, rnd_vec(), $urandom, 8'hF8 | 8'(l), 2'd0, 1'b0, "R5 three-op lane");
    apply(2'd3, rnd_vec(), 32'hFFFF_1234, 8'h05, 2'd0, 1'b0, "R5 mode3 three-op");
    apply(2'd0, rnd_vec(), 32'hABCD_5A5A, 8'h02, 2'd0, 1'b0, "R2 scalar upper ignored");

    v = rnd_vec();
    apply(2'd1, v, 32'h0, 8'h03, 2'd0, 1'b0, "R4 prior write");
    for (int vl = 1; vl < 4; vl++)
      apply(2'd2, rnd_vec(), $urandom, 8'($urandom), 2'(vl), 1'b0, "R6 fault no write");
    apply(2'd1, rnd_vec(), $urandom, 8'h06, 2'd1, 1'b0, "R6 legacy no fault");
    apply(2'd0, rnd_vec(), $urandom, 8'h01, 2'd3, 1'b0, "R6 narrow no fault");

    v = rnd_vec();
    apply(2'd2, v, 32'h7777_BEEF, 8'h04, 2'd0, 1'b0, "R7 w=0");
    apply(2'd2, v, 32'h7777_BEEF, 8'h04, 2'd0, 1'b1, "R7 w=1");
    apply(2'd1, v, 32'h0000_1111, 8'h07, 2'd0, 1'b1, "R7 legacy w=1");
    apply(2'd3, v, 32'h0, 8'h00, 2'd2, 1'b1, "R7 fault w=1");

    idle(4);
    @(negedge clk);
    compare("R8 idle hold", held, 1'b0, 1'b0);

    for (int n = 0; n < 150; n++)
      apply(2'($urandom), rnd_vec(), $urandom, 8'($urandom),
            ($urandom % 4 == 0) ? 2'($urandom) : 2'd0, 1'($urandom), "R8 random stream");
    idle(3);
    @(negedge clk);
    compare("R8 final hold", held, 1'b0, 1'b0);
    if (sb.size() != 0) begin
      n_vec++; n_bad++;
      $display("FAIL R8: %0d results missing, expected 0", sb.size());
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule